// File: doc/BRIEF.md
# Soft-Start Bias Ramp Sequencer

This block sequences one half-bridge output of a switching audio power stage through power-up and power-down. When ramping is in effect and the channel is brought out of reset, the output stays tri-stated until the incoming PWM stream is seen toggling. The output is then enabled and driven by an internal low-rate PWM whose duty grows step by step from zero to the mid-supply bias point. Only at that point does the incoming PWM stream take over the output.

When the channel is put back into reset, the level is walked back down to zero before the output is released to tri-state. A ramp in either direction can be reversed at any level, and it continues from where it stood. With ramping switched off, or in an output mode that does not allow it, the channel switches normally as soon as it leaves reset and tri-states as soon as it enters reset.

The channel reset, ramp-enable and PWM inputs are synchronized with two flops each. The mode input is treated as a static strap.

Top module: `bias_ramp_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `out_en`, `drive` and `level` are all zero.
- R2: When ramping is in effect, the up-ramp starts when `out_en` rises with `level` at 0. `level` then grows by one every `UP_STEP` cycles and reaches LVL_MAX = 2^LVL_W-1 exactly LVL_MAX*UP_STEP cycles after `out_en` rose. From then on, `drive` follows the synchronized PWM input.
- R3: Before an up-ramp from rest, `out_en` stays low and `level` stays 0 until at least `ACT_EDGES` edges of the synchronized PWM input fall inside one `ACT_WIN`-cycle window. A static input, or toggling that is too sparse, never starts the ramp.
- R4: When the channel reset falls while the channel is running with ramping in effect, `level` drops by one every `DN_STEP` cycles. `out_en` stays high while `level` is above 0. `out_en` falls in the same cycle that `level` reaches 0, which is (LVL_MAX-1)*DN_STEP cycles after `level` first drops below LVL_MAX.
- R5: A reset change during a ramp reverses its direction from the current `level`, with no jump larger than one step. An up-reversal does not wait for PWM activity, and `out_en` stays high throughout.
- R6: When ramping is not in effect, `out_en` rises with `level` = LVL_MAX on the third clock edge after `chan_rst_n` rises. `out_en` falls with `level` = 0 on the third edge after `chan_rst_n` falls.
- R7: In the running state, `drive` equals `pwm_in` delayed by exactly two clock edges.
- R8: `mode` codes 0 (half-bridge), 2 and 3 (full-bridge with internal inversion) honour `ramp_en`. Codes 1 (full-bridge with external inversion) and 4 to 7 ignore it.
- R9: During a ramp, `drive` is high exactly when a free-running counter is below `level`. The counter is cleared by `rst`, advances every cycle and wraps modulo 2^(LVL_W+1), so the full code gives just under 50% duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| chan_rst_n | input | 1 | Channel reset, active low, asynchronous to clk |
| ramp_en | input | 1 | Ramp-enable strap, asynchronous to clk |
| mode | input | 3 | Output mode code (see R8), static while running |
| pwm_in | input | 1 | Channel PWM stream from the modulator |
| drive | output | 1 | Switch-stage drive level |
| out_en | output | 1 | Output enable; low means tri-state |
| level | output | LVL_W | Current ramp level code |

## Verification
The bench checks that the up-ramp waits for real input activity. Sparse toggling is applied, and a design that counted edges without a window would start the ramp too early. The bench times both ramps to the exact cycle, so an off-by-one step timer or a down-ramp that tri-states one step early shows up as a wrong count. It flips the channel reset in the middle of a ramp and watches for a level jump, a drop to zero or a stall on missing activity, which are the typical faults of a sequencer that restarts instead of reversing. It also compares the ramp drive against the counter model every cycle, and checks that modes which must ignore the strap switch straight away.

// File: rtl/bias_ramp_pkg.sv
package bias_ramp_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_WAIT = 3'd1,
        ST_UP   = 3'd2,
        ST_RUN  = 3'd3,
        ST_DN   = 3'd4
    } seq_state_e;

    localparam logic [2:0] MODE_HALF         = 3'd0;
    localparam logic [2:0] MODE_FB_EXT_INV   = 3'd1;
    localparam logic [2:0] MODE_FB_INV_AUTO  = 3'd2;
    localparam logic [2:0] MODE_FB_INV_LATCH = 3'd3;

    typedef struct packed {
        logic chan_on;
        logic ramp_req;
        logic pwm;
    } sync_bits_t;

    function automatic logic ramp_allowed(input logic [2:0] m);
        return (m == MODE_HALF) || (m == MODE_FB_INV_AUTO) || (m == MODE_FB_INV_LATCH);
    endfunction

endpackage

// File: rtl/brs_sync.sv
module brs_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, out_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                out_q  <= 1'b0;
            end else begin
                meta_q <= d[i];
                out_q  <= meta_q;
            end
        end
        assign q[i] = out_q;
    end
endmodule

// File: rtl/brs_activity.sv
module brs_activity #(
    parameter int ACT_EDGES = 4,
    parameter int ACT_WIN   = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic sig,
    output logic seen
);
    localparam int EC_W  = $clog2(ACT_EDGES + 1);
    localparam int WIN_W = $clog2(ACT_WIN) + 1;

    logic             sig_d;
    logic [EC_W-1:0]  edge_cnt;
    logic [WIN_W-1:0] win_cnt;
    logic             edge_hit;

    assign edge_hit = sig ^ sig_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_d    <= 1'b0;
            edge_cnt <= '0;
            win_cnt  <= '0;
        end else if (!arm) begin
            sig_d    <= sig;
            edge_cnt <= '0;
            win_cnt  <= '0;
        end else begin
            sig_d <= sig;
            if (win_cnt == WIN_W'(ACT_WIN - 1)) begin
                win_cnt  <= '0;
                edge_cnt <= '0;
            end else begin
                win_cnt <= win_cnt + 1'b1;
                if (edge_hit && edge_cnt != EC_W'(ACT_EDGES))
                    edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

    assign seen = (edge_cnt == EC_W'(ACT_EDGES));

    // R3: a disarmed detector never reports activity on the next cycle
    assert_disarm_clears_R3: assert property (@(posedge clk) disable iff (rst)
        !arm |=> !seen);
endmodule

// File: rtl/brs_ramp_pwm.sv
module brs_ramp_pwm #(
    parameter int LVL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    output logic             drv
);
    logic [LVL_W:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign drv = ({1'b0, level} > cnt_q);

    // R9: the upper half of every period is low, so duty stays below half
    assert_half_period_low_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q[LVL_W] |-> !drv);
endmodule

// File: rtl/bias_ramp_seq.sv
module bias_ramp_seq
    import bias_ramp_pkg::*;
#(
    parameter int LVL_W     = 10,
    parameter int UP_STEP   = 73314,    // about 1.5 s over the full code at 50 MHz
    parameter int DN_STEP   = 2443793,  // about 50 s over the full code at 50 MHz
    parameter int ACT_EDGES = 4,
    parameter int ACT_WIN   = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_rst_n,
    input  logic             ramp_en,
    input  logic [2:0]       mode,
    input  logic             pwm_in,
    output logic             drive,
    output logic             out_en,
    output logic [LVL_W-1:0] level
);
    localparam int STEP_MAX = (UP_STEP > DN_STEP) ? UP_STEP : DN_STEP;
    localparam int STEP_W   = $clog2(STEP_MAX) + 1;
    localparam logic [LVL_W-1:0] LVL_MAX = '1;
    localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);

    sync_bits_t raw_in, syn;
    seq_state_e state_q;
    logic [LVL_W-1:0]  level_q;
    logic [STEP_W-1:0] step_q;
    logic ramp_ok, act_seen, ramp_drv, arm;

    assign raw_in = '{chan_on: chan_rst_n, ramp_req: ramp_en, pwm: pwm_in};

    brs_sync #(.W($bits(sync_bits_t))) sync_i (
        .clk (clk), .rst (rst), .d (raw_in), .q (syn)
    );

    assign ramp_ok = syn.ramp_req && ramp_allowed(mode);
    assign arm     = (state_q == ST_WAIT);

    brs_activity #(.ACT_EDGES(ACT_EDGES), .ACT_WIN(ACT_WIN)) act_i (
        .clk (clk), .rst (rst), .arm (arm), .sig (syn.pwm), .seen (act_seen)
    );

    brs_ramp_pwm #(.LVL_W(LVL_W)) rpwm_i (
        .clk (clk), .rst (rst), .level (level_q), .drv (ramp_drv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            level_q <= '0;
            step_q  <= '0;
        end else begin
            case (state_q)
                ST_OFF: begin
                    step_q  <= '0;
                    level_q <= '0;
                    if (syn.chan_on) begin
                        if (ramp_ok) begin
                            state_q <= ST_WAIT;
                        end else begin
                            state_q <= ST_RUN;
                            level_q <= LVL_MAX;
                        end
                    end
                end
                ST_WAIT: begin
                    step_q <= '0;
                    if (!syn.chan_on)  state_q <= ST_OFF;
                    else if (act_seen) state_q <= ST_UP;
                end
                ST_UP: begin
                    if (!syn.chan_on) begin
                        step_q  <= '0;
                        state_q <= (level_q == '0) ? ST_OFF : ST_DN;
                    end else if (step_q == STEP_W'(UP_STEP - 1)) begin
                        step_q  <= '0;
                        level_q <= level_q + LVL_ONE;
                        if (level_q == LVL_MAX - LVL_ONE) state_q <= ST_RUN;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                ST_RUN: begin
                    step_q <= '0;
                    if (!syn.chan_on) begin
                        if (ramp_ok) begin
                            state_q <= ST_DN;
                        end else begin
                            state_q <= ST_OFF;
                            level_q <= '0;
                        end
                    end
                end
                ST_DN: begin
                    if (syn.chan_on) begin
                        step_q  <= '0;
                        state_q <= ST_UP;
                    end else if (step_q == STEP_W'(DN_STEP - 1)) begin
                        step_q  <= '0;
                        level_q <= level_q - LVL_ONE;
                        if (level_q == LVL_ONE) state_q <= ST_OFF;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_OFF;
                    level_q <= '0;
                    step_q  <= '0;
                end
            endcase
        end
    end

    always_comb begin
        out_en = 1'b0;
        drive  = 1'b0;
        case (state_q)
            ST_UP, ST_DN: begin out_en = 1'b1; drive = ramp_drv; end
            ST_RUN:       begin out_en = 1'b1; drive = syn.pwm;  end
            default:      begin out_en = 1'b0; drive = 1'b0;     end
        endcase
    end

    assign level = level_q;

    // R3: an up-ramp is never entered straight from rest
    assert_no_skip_wait_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_UP) |-> ($past(state_q) != ST_OFF));

    // R2: the level never falls while the up-ramp continues
    assert_up_monotone_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_UP && $past(state_q) == ST_UP) |-> (level_q >= $past(level_q)));

    // R4: the output is released only once the level is zero
    assert_release_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(out_en) |-> (level_q == '0));

    // R5: a reversal keeps the current level
    assert_reverse_keeps_level_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_DN && state_q == ST_UP) |-> (level_q == $past(level_q)));

    // R8: modes without ramping never enter the activity wait
    assert_mode_gate_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_OFF && !ramp_allowed($past(mode))) |-> (state_q != ST_WAIT));
endmodule

// File: tb/bias_ramp_seq_tb_top.sv
module bias_ramp_seq_tb_top;
    localparam int LW = 10;
    localparam int UPS = 2;
    localparam int DNS = 3;
    localparam int LMAX = (1 << LW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chan_rst_n = 1'b0;
    logic ramp_en = 1'b0;
    logic [2:0] mode = 3'd0;
    logic pwm_drv = 1'b0;
    logic tog_on = 1'b0;
    logic tog_val = 1'b0;
    logic [7:0] tog_cnt = '0;
    logic pwm_in;
    logic drive, out_en;
    logic [LW-1:0] level;

    int checks = 0;
    int errors = 0;
    int bc = 0;
    logic h1 = 1'b0, h2 = 1'b0;

    always #4 clk = ~clk;

    assign pwm_in = tog_on ? tog_val : pwm_drv;

    always @(negedge clk) begin
        tog_cnt <= tog_cnt + 1'b1;
        if (tog_cnt[0]) tog_val <= ~tog_val;
    end

    // model of the ramp counter (R9) and the two-edge input lag (R7)
    always @(posedge clk) begin
        if (rst) bc <= 0;
        else     bc <= (bc + 1) % (1 << (LW + 1));
        h1 <= pwm_in;
        h2 <= h1;
    end

    bias_ramp_seq #(.LVL_W(LW), .UP_STEP(UPS), .DN_STEP(DNS),
                    .ACT_EDGES(4), .ACT_WIN(16)) dut_i (
        .clk (clk), .rst (rst), .chan_rst_n (chan_rst_n), .ramp_en (ramp_en),
        .mode (mode), .pwm_in (pwm_in), .drive (drive), .out_en (out_en), .level (level)
    );

    // passthrough table: {stimulus, expected drive} where expected is stimulus two rows earlier
    localparam logic [1:0] PT_TAB [12] = '{
        2'b10, 2'b00, 2'b11, 2'b10, 2'b01, 2'b01,
        2'b10, 2'b00, 2'b11, 2'b10, 2'b11, 2'b01
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, prev, bad_duty, bad_step, lv0, lvr;
        cyc(4);
        // R1: reset state
        chk(out_en == 0 && drive == 0 && level == 0, "R1 reset state", {out_en, drive}, 0);
        rst = 1'b0;
        cyc(2);

        // R6: no ramping, immediate start
        chan_rst_n = 1'b1;
        cyc(3);
        chk(out_en == 1, "R6 enable on third edge", out_en, 1);
        chk(level == LW'(LMAX), "R6 level full at run", level, LMAX);

        // R7: passthrough table
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(drive == PT_TAB[i][0], "R7 passthrough lag", drive, PT_TAB[i][0]);
            pwm_drv = PT_TAB[i][1];
        end
        pwm_drv = 1'b0;

        chan_rst_n = 1'b0;
        cyc(3);
        chk(out_en == 0 && level == 0 && drive == 0, "R6 immediate tri-state", out_en, 0);

        // R8: modes that ignore the strap
        ramp_en = 1'b1;
        mode = 3'd1;
        cyc(4);
        chan_rst_n = 1'b1;
        cyc(3);
        chk(out_en == 1, "R8 mode 1 ignores ramp", out_en, 1);
        chan_rst_n = 1'b0;
        cyc(3);
        chk(out_en == 0, "R8 mode 1 immediate off", out_en, 0);
        mode = 3'd5;
        chan_rst_n = 1'b1;
        cyc(3);
        chk(out_en == 1, "R8 mode 5 ignores ramp", out_en, 1);
        chan_rst_n = 1'b0;
        cyc(3);
        mode = 3'd2;
        chan_rst_n = 1'b1;
        cyc(20);
        chk(out_en == 0 && level == 0, "R8 mode 2 honours ramp", out_en, 0);
        chan_rst_n = 1'b0;
        cyc(4);

        // R3: activity gate
        mode = 3'd0;
        chan_rst_n = 1'b1;
        cyc(100);
        chk(out_en == 0 && level == 0, "R3 static input waits", out_en, 0);
        for (int i = 0; i < 10; i++) begin
            pwm_drv = ~pwm_drv;
            cyc(10);
        end
        chk(out_en == 0 && level == 0, "R3 sparse edges wait", out_en, 0);

        // R2 and R9: up-ramp
        tog_on = 1'b1;
        n = 0;
        while (out_en == 0 && n < 200) begin @(negedge clk); n++; end
        chk(out_en == 1 && level == 0, "R2 ramp starts at zero", level, 0);
        n = 0; prev = 0; bad_duty = 0; bad_step = 0;
        forever begin
            if (drive != (bc < int'(level))) bad_duty++;
            @(negedge clk);
            n++;
            if (int'(level) != prev && int'(level) != prev + 1) bad_step++;
            prev = int'(level);
            if (level == LW'(LMAX) || n > 5000) break;
        end
        chk(n == LMAX * UPS, "R2 up-ramp duration", n, LMAX * UPS);
        chk(bad_step == 0, "R2 single steps", bad_step, 0);
        chk(bad_duty == 0, "R9 ramp duty model", bad_duty, 0);
        bad_duty = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (drive != h2) bad_duty++;
        end
        chk(bad_duty == 0, "R2 handoff to input", bad_duty, 0);

        // R4: down-ramp
        chan_rst_n = 1'b0;
        n = 0;
        while (level == LW'(LMAX) && n < 20) begin @(negedge clk); n++; end
        n = 0; bad_step = 0; bad_duty = 0;
        forever begin
            @(negedge clk);
            n++;
            if (out_en == 1 && drive != (bc < int'(level))) bad_duty++;
            if (out_en == 0 || n > 5000) break;
        end
        chk(n == (LMAX - 1) * DNS, "R4 down-ramp duration", n, (LMAX - 1) * DNS);
        chk(level == 0, "R4 level zero at release", level, 0);
        chk(bad_duty == 0, "R9 down-ramp duty model", bad_duty, 0);

        // R5: reversal
        chan_rst_n = 1'b1;
        n = 0;
        while (level < 100 && n < 1000) begin @(negedge clk); n++; end
        tog_on = 1'b0;
        chan_rst_n = 1'b0;
        lv0 = int'(level);
        prev = lv0; bad_step = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (out_en == 0) bad_step++;
            if (int'(level) > prev + 1 || int'(level) < prev - 1) bad_step++;
            prev = int'(level);
        end
        chk(bad_step == 0, "R5 smooth down reversal", bad_step, 0);
        chk(int'(level) < lv0 && int'(level) > lv0 - 25, "R5 falls from current level", level, lv0 - 18);
        chan_rst_n = 1'b1;
        lvr = int'(level);
        cyc(40);
        chk(out_en == 1 && int'(level) > lvr, "R5 up reversal without activity", level, lvr + 17);
        n = 0;
        while (level != LW'(LMAX) && n < 3000) begin @(negedge clk); n++; end
        chk(level == LW'(LMAX), "R5 reversal completes", level, LMAX);

        // R6: strap off, immediate shutdown from a ramped run
        ramp_en = 1'b0;
        cyc(4);
        chan_rst_n = 1'b0;
        cyc(3);
        chk(out_en == 0 && level == 0, "R6 shutdown without ramp", out_en, 0);

        // R1: block reset while running
        chan_rst_n = 1'b1;
        cyc(4);
        chk(out_en == 1, "R6 restart without ramp", out_en, 1);
        rst = 1'b1;
        cyc(1);
        chk(out_en == 0 && level == 0 && drive == 0, "R1 reset while running", out_en, 0);
        rst = 1'b0;
        cyc(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule